// File: doc/BRIEF.md
# Display Start Position Delay Generator

This block places the top-left corner of an on-screen overlay inside the active video. It runs on the pixel clock and watches the horizontal and vertical sync inputs. After each vertical sync edge it counts scan lines, in units of four lines per programmed step. After each horizontal sync edge it counts pixel clocks, in units of half a character cell.

When the programmed offset on an axis has elapsed, that axis gives a single-cycle start strobe. The half-cell unit is five dots for the narrow font and six dots for the wide font. The overlay renderer downstream uses the two strobes as the origin of its raster. Two 8-bit delay values are loaded through simple write strobes. Sync inputs are expected to be active-high and already aligned to the pixel clock.

Top module: `disp_origin_gen`

## Requirements
- R1: While reset is asserted and after it, both strobes are low. The vertical delay loads 4 and the horizontal delay loads 15, so with no writes the vertical start follows 16 lines and the horizontal start follows 75 clocks (narrow font).
- R2: `v_start` is high for the cycle whose clock edge captures the (4 × vertical delay)-th `hsync` rising edge after the most recent captured `vsync` rising edge.
- R3: A vertical delay write of 0 is stored as 1, so the vertical start then follows 4 lines. The stored vertical delay is never 0.
- R4: `h_start` is high exactly step × horizontal delay clocks after the edge that captures an `hsync` rising edge. The step is 5 when `font_wide` is 0 and 6 when it is 1.
- R5: With a horizontal delay of 0, `h_start` is high in the cycle of the edge that captures the `hsync` rising edge. It fires once, even though `hsync` stays high longer.
- R6: Each strobe is one clock wide and fires at most once per captured sync rising edge.
- R7: A sync rising edge restarts the count on its axis. If it lands on the edge where the old count would have reached its target, no strobe is given for the old count. An `hsync` rising edge captured in the same cycle as a `vsync` rising edge is not counted as a line.
- R8: A delay write is used for comparison from the second clock edge after the write strobe is sampled. If the running count already meets or exceeds the new target at that edge, the strobe fires at that edge.
- R9: Sync edges are detected only on low-to-high transitions. A sync held high does not retrigger its counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync | input | 1 | Horizontal sync, active high |
| vsync | input | 1 | Vertical sync, active high |
| font_wide | input | 1 | 0: 10-dot font (5-dot step), 1: 12-dot font (6-dot step) |
| vdly_we | input | 1 | Write strobe for the vertical delay |
| vdly_wdata | input | 8 | Vertical delay value, in steps of four lines |
| hdly_we | input | 1 | Write strobe for the horizontal delay |
| hdly_wdata | input | 8 | Horizontal delay value, in half-cell steps |
| v_start | output | 1 | One-cycle vertical start strobe |
| h_start | output | 1 | One-cycle horizontal start strobe |

## Verification
A counter restart and a terminal count can fall on the same clock edge. The bench provokes this by setting the horizontal target equal to the line length. The next `hsync` edge then arrives exactly when the old count would fire, and the scoreboard expects no strobe from that line, only the one from the line that follows. The second coincidence is a `vsync` and an `hsync` rising edge in the same cycle. The bench judges it by the line count: the vertical strobe must fall on the fourth later line, not the third. A delay write that lands mid-count is also checked. It must produce the strobe on the second edge after the write.

// File: rtl/disp_origin_pkg.sv
package disp_origin_pkg;

    typedef enum logic {
        FONT_NARROW = 1'b0,
        FONT_WIDE   = 1'b1
    } font_sel_e;

    function automatic int unsigned cnt_width(input int unsigned max_val);
        return $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/sync_rise_det.sv
module sync_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = sync_in;
        rise   = sync_in & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    // R9
    rise_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/delay_regs.sv
module delay_regs #(
    parameter int unsigned DLY_W   = 8,
    parameter int unsigned V_RESET = 4,
    parameter int unsigned H_RESET = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vdly_we,
    input  logic [DLY_W-1:0] vdly_wdata,
    input  logic             hdly_we,
    input  logic [DLY_W-1:0] hdly_wdata,
    output logic [DLY_W-1:0] vdly,
    output logic [DLY_W-1:0] hdly
);
    typedef struct packed {
        logic [DLY_W-1:0] v;
        logic [DLY_W-1:0] h;
    } regs_t;

    regs_t d, q;

    always_comb begin
        d = q;
        if (vdly_we) begin
            d.v = (vdly_wdata == '0) ? DLY_W'(1) : vdly_wdata;
        end
        if (hdly_we) begin
            d.h = hdly_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.v <= DLY_W'(V_RESET);
            q.h <= DLY_W'(H_RESET);
        end else begin
            q <= d;
        end
    end

    assign vdly = q.v;
    assign hdly = q.h;

    // R3
    vdly_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vdly != '0);

    // R8
    hdly_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdly_we |=> (hdly == $past(hdly_wdata)));

endmodule

// File: rtl/axis_delay_cnt.sv
module axis_delay_cnt #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] target,
    output logic             strobe
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             strobe;
    } cnt_state_t;

    cnt_state_t d, q;
    logic [CNT_W:0] cnt_inc;

    always_comb begin
        d        = q;
        d.strobe = 1'b0;
        cnt_inc  = {1'b0, q.cnt} + 1'b1;
        if (restart) begin
            d.cnt = '0;
            if (target == '0) begin
                d.strobe = 1'b1;
                d.armed  = 1'b0;
            end else begin
                d.armed  = 1'b1;
            end
        end else if (q.armed && tick) begin
            if (cnt_inc >= {1'b0, target}) begin
                d.strobe = 1'b1;
                d.armed  = 1'b0;
            end else begin
                d.cnt = cnt_inc[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign strobe = q.strobe;

    // R6
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    // R7
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && target != '0) |=> !strobe);

    // R6
    strobe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe) |-> ($past(q.armed) || $past(restart)));

endmodule

// File: rtl/disp_origin_gen.sv
module disp_origin_gen #(
    parameter int unsigned DLY_W       = 8,
    parameter int unsigned V_STEP      = 4,
    parameter int unsigned NARROW_STEP = 5,
    parameter int unsigned WIDE_STEP   = 6,
    parameter int unsigned V_RESET     = 4,
    parameter int unsigned H_RESET     = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync,
    input  logic             vsync,
    input  logic             font_wide,
    input  logic             vdly_we,
    input  logic [DLY_W-1:0] vdly_wdata,
    input  logic             hdly_we,
    input  logic [DLY_W-1:0] hdly_wdata,
    output logic             v_start,
    output logic             h_start
);
    import disp_origin_pkg::*;

    localparam int unsigned DLY_MAX = (1 << DLY_W) - 1;
    localparam int unsigned VCNT_W  = cnt_width(V_STEP * DLY_MAX);
    localparam int unsigned HCNT_W  = cnt_width(WIDE_STEP * DLY_MAX);

    logic             h_rise, v_rise;
    logic [DLY_W-1:0] vdly, hdly;
    logic [VCNT_W-1:0] v_target;
    logic [HCNT_W-1:0] h_step, h_target;
    font_sel_e         font;

    sync_rise_det u_hdet (.clk(clk), .rst_n(rst_n), .sync_in(hsync), .rise(h_rise));
    sync_rise_det u_vdet (.clk(clk), .rst_n(rst_n), .sync_in(vsync), .rise(v_rise));

    delay_regs #(
        .DLY_W(DLY_W), .V_RESET(V_RESET), .H_RESET(H_RESET)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .vdly_we(vdly_we), .vdly_wdata(vdly_wdata),
        .hdly_we(hdly_we), .hdly_wdata(hdly_wdata),
        .vdly(vdly), .hdly(hdly)
    );

    always_comb begin
        font     = font_sel_e'(font_wide);
        h_step   = (font == FONT_WIDE) ? HCNT_W'(WIDE_STEP) : HCNT_W'(NARROW_STEP);
        h_target = HCNT_W'(hdly) * h_step;
        v_target = VCNT_W'(vdly) * VCNT_W'(V_STEP);
    end

    // Vertical axis: restart on frame edge, advance on each line edge.
    axis_delay_cnt #(.CNT_W(VCNT_W)) u_vcnt (
        .clk(clk), .rst_n(rst_n),
        .restart(v_rise), .tick(h_rise),
        .target(v_target), .strobe(v_start)
    );

    // Horizontal axis: restart on line edge, advance every pixel clock.
    axis_delay_cnt #(.CNT_W(HCNT_W)) u_hcnt (
        .clk(clk), .rst_n(rst_n),
        .restart(h_rise), .tick(1'b1),
        .target(h_target), .strobe(h_start)
    );

    // R2
    v_on_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(v_start) |-> $past(h_rise));

    // R7
    v_frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_rise |=> !v_start);

endmodule

// File: tb/test_disp_origin_gen.sv
module test_disp_origin_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync = 1'b0, vsync = 1'b0, font_wide = 1'b0;
    logic       vdly_we = 1'b0, hdly_we = 1'b0;
    logic [7:0] vdly_wdata = '0, hdly_wdata = '0;
    logic       v_start, h_start;

    always #10 clk = ~clk;

    disp_origin_gen i_disp_origin_gen (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
        .font_wide(font_wide), .vdly_we(vdly_we), .vdly_wdata(vdly_wdata),
        .hdly_we(hdly_we), .hdly_wdata(hdly_wdata),
        .v_start(v_start), .h_start(h_start)
    );

    int    cyc = 0;
    int    n_cmp = 0, n_bad = 0;
    bit    done = 1'b0;
    int    hq[$], vq[$];
    string htag[$], vtag[$];

    int hd = 15, vd = 4, vline = 0;
    bit varmed = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: pop expected strobe cycles as strobes appear.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (h_start) begin
                if (hq.size() == 0) check("R6 R7 h_start unexpected", cyc, -1);
                else check(htag.pop_front(), cyc, hq.pop_front());
            end
            if (v_start) begin
                if (vq.size() == 0) check("R6 R7 v_start unexpected", cyc, -1);
                else check(vtag.pop_front(), cyc, vq.pop_front());
            end
        end
    end

    task automatic wr_h(input int v);
        hdly_we = 1'b1; hdly_wdata = 8'(v);
        @(negedge clk);
        hdly_we = 1'b0;
        hd = v;
    endtask

    task automatic wr_v(input int v);
        vdly_we = 1'b1; vdly_wdata = 8'(v);
        @(negedge clk);
        vdly_we = 1'b0;
        vd = (v == 0) ? 1 : v;
    endtask

    task automatic vs_pulse();
        vsync = 1'b1;
        @(negedge clk);
        vsync = 1'b0;
        repeat (3) @(negedge clk);
        varmed = 1'b1; vline = 0;
    endtask

    // Driver: one line of len clocks, pushing expected strobe cycles.
    task automatic line(input int len, input bit with_vs, input string tag);
        int drive, ht;
        drive = cyc;
        hsync = 1'b1;
        if (with_vs) vsync = 1'b1;
        ht = hd * (font_wide ? 6 : 5);
        if (ht < len) begin
            hq.push_back(drive + 1 + ht); htag.push_back(tag);
        end
        if (with_vs) begin
            varmed = 1'b1; vline = 0;
        end else if (varmed) begin
            vline++;
            if (vline == 4 * vd) begin
                vq.push_back(drive + 1); vtag.push_back(tag);
                varmed = 1'b0;
            end
        end
        @(negedge clk); vsync = 1'b0;
        @(negedge clk); hsync = 1'b0;
        repeat (len - 2) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 h_start in reset", int'(h_start), 0);
        check("R1 v_start in reset", int'(v_start), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 h_start after reset", int'(h_start), 0);
        check("R1 v_start after reset", int'(v_start), 0);

        // R1 R2 R4: default delays, narrow font
        vs_pulse();
        for (int i = 0; i < 17; i++) line(120, 1'b0, "R1 R2 R4 default");

        // R4: wide font step
        font_wide = 1'b1;
        for (int i = 0; i < 2; i++) line(120, 1'b0, "R4 wide step");

        // R5 R9: zero horizontal delay, sync held two cycles
        wr_h(0);
        for (int i = 0; i < 2; i++) line(120, 1'b0, "R5 R9 zero hdelay");

        // R3: zero vertical delay acts as one step
        wr_v(0);
        vs_pulse();
        for (int i = 0; i < 5; i++) line(120, 1'b0, "R3 zero vdelay");

        // R2 R4: other values, wide font
        wr_v(2); wr_h(10);
        vs_pulse();
        for (int i = 0; i < 9; i++) line(120, 1'b0, "R2 R4 vd2 hd10");

        // R7: restart on the terminal edge suppresses the strobe
        font_wide = 1'b0;
        wr_h(20);
        line(100, 1'b0, "R7 collision");
        line(120, 1'b0, "R7 after collision");

        // R7: hsync with vsync in the same cycle is not a line
        wr_v(1);
        line(120, 1'b1, "R7 joint edge");
        for (int i = 0; i < 4; i++) line(120, 1'b0, "R7 joint edge");

        // R8: write lowering the target mid-count
        wr_h(15);
        begin
            int c0;
            c0 = cyc;
            hsync = 1'b1;
            hq.push_back(c0 + 42); htag.push_back("R8 mid-count write");
            @(negedge clk);
            @(negedge clk); hsync = 1'b0;
            repeat (38) @(negedge clk);
            wr_h(4);
            repeat (79) @(negedge clk);
        end
        line(120, 1'b0, "R8 new target");
        repeat (200) @(negedge clk);

        while (hq.size() > 0) begin
            check({"missing h_start ", htag.pop_front()}, -1, hq.pop_front());
        end
        while (vq.size() > 0) begin
            check({"missing v_start ", vtag.pop_front()}, -1, vq.pop_front());
        end
        finish_run();
    end

    always @(negedge clk) begin
        if (cyc > 150000 && !done) begin
            check("watchdog R1", cyc, 150000);
            finish_run();
        end
    end

endmodule